// File: doc/BRIEF.md
# One-Hot Change Event Monitor

This block watches a group of request lines. At most one line is high at a time. Every time the synchronized request vector moves to a new non-zero value, the block does two things. It adds one to an event counter, and it starts a fixed-width output pulse. A new event that arrives while the pulse is high reloads the pulse timer, so the pulse is stretched rather than cut short.

The event counter has a separate clear request that acts only on its rising edge. Holding the clear line high does not freeze the counter, so events counted after the edge build up from zero again.

All inputs pass through two-flop synchronizers before any logic uses them, and the whole block runs from one clock. With the default pulse length of 1250 cycles, the pulse lasts 25 microseconds at 50 MHz.

Top module: `chg_event_mon`

## Requirements
- R1: While `rst_n` is low, `evt_count_o` is 0 and `pulse_o` is 0.
- R2: A change event occurs when `req_i` settles on a one-hot value that is non-zero and differs from the value it held one cycle earlier. Going from idle to any line counts as an event. On each event `evt_count_o` increases by exactly one. The new value appears after the third rising clock edge that follows the input change: two synchronizer stages and then the counter register.
- R3: A transition of `req_i` to all zeros is not an event. It leaves `evt_count_o` unchanged and does not raise `pulse_o`.
- R4: `evt_count_o` is 16 bits wide and wraps from 16'hFFFF to 0 on the next event.
- R5: `pulse_o` rises on the same clock edge as the counter update for an event. It stays high for exactly `PULSE_CYC` cycles (default 1250) after that edge.
- R6: An event that arrives while `pulse_o` is high reloads the timer. The pulse then stays high for `PULSE_CYC` cycles counted from the newer event.
- R7: After the pulse has expired, `pulse_o` stays low for as long as no new event arrives. The timer never wraps around and re-raises the output.
- R8: A 0-to-1 transition of `clr_req_i` sets `evt_count_o` to 0, with the same three-edge latency as R2. Keeping `clr_req_i` high afterwards does not hold the count at zero, and later events increment it.
- R9: When a clear edge and a change event reach the counter in the same cycle, the clear wins and `evt_count_o` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | 4 | One-hot request lines, asynchronous to `clk` |
| clr_req_i | input | 1 | Counter clear request, acts on its rising edge |
| evt_count_o | output | 16 | Event count |
| pulse_o | output | 1 | Retriggerable fixed-width event pulse |

## Verification
The request lines are driven through several patterns. The first is idle-to-line, which shows the three-edge latency. The next are line-to-line moves, which are ordinary events. A drop to all zeros shows that releasing a line is not counted, and a return to the same line after idle shows that it is counted. The last is a 65,536-step alternation between two lines, which takes the counter across its wrap point.

Two pulse cases are measured in cycles. A lone event gives the plain width, and an event arriving mid-pulse gives a stretched width. A long quiet window after expiry exposes any timer wrap. The clear request is tested twice: held high while events continue, to separate edge action from level action, and raised in the same cycle as an event, to show which one has priority.

// File: rtl/cem_pkg.sv
package cem_pkg;
  // Decoded events delivered to the counter and the pulse timer.
  typedef struct packed {
    logic chg;       // one-hot vector moved to a new non-zero value
    logic clr_edge;  // rising edge of the clear request
  } cem_evt_t;
endpackage

// File: rtl/cem_sync.sv
module cem_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cem_change_det.sv
module cem_change_det
  import cem_pkg::*;
#(
  parameter int unsigned LINES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_s_i,
  input  logic             clr_s_i,
  output cem_evt_t         evt_o
);
  logic [LINES-1:0] prev_q, prev_d;
  logic             prev_clr_q, prev_clr_d;

  always_comb begin
    prev_d         = req_s_i;
    prev_clr_d     = clr_s_i;
    evt_o.chg      = (req_s_i != prev_q) && (|req_s_i);
    evt_o.clr_edge = clr_s_i && !prev_clr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= '0;
      prev_clr_q <= 1'b0;
    end else begin
      prev_q     <= prev_d;
      prev_clr_q <= prev_clr_d;
    end
  end

  // R2: the synchronized request vector is expected to stay one-hot or idle
  p_onehot_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_s_i));

  // R3: a drop to idle never produces an event
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_s_i == '0) |-> !evt_o.chg);
endmodule

// File: rtl/cem_evt_counter.sv
module cem_evt_counter
  import cem_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cem_evt_t         evt_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = evt_i.clr_edge || evt_i.chg;
    if (evt_i.clr_edge) cnt_d = '0;           // clear has priority
    else                cnt_d = cnt_q + 1'b1; // natural wrap at all ones
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.clr_edge |=> (count_o == '0));

  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.clr_edge && evt_i.chg) |=> (count_o == '0));

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.chg && !evt_i.clr_edge) |=> (count_o == $past(count_o) + 1'b1));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i.chg && !evt_i.clr_edge) |=> $stable(count_o));
endmodule

// File: rtl/cem_pulse_timer.sv
module cem_pulse_timer #(
  parameter int unsigned PULSE_CYC = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int unsigned TW = $clog2(PULSE_CYC + 1);
  localparam logic [TW-1:0] RELOAD = TW'(PULSE_CYC);

  logic [TW-1:0] rem_q, rem_d;
  logic          rem_en;

  always_comb begin
    rem_en = trig_i || (rem_q != '0);
    if (trig_i) rem_d = RELOAD;          // retrigger reloads the full width
    else        rem_d = rem_q - 1'b1;    // only taken while non-zero: clamps at 0
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign pulse_o = (rem_q != '0);

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> (pulse_o && rem_q == RELOAD));

  p_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && rem_q != '0) |=> (rem_q == $past(rem_q) - 1'b1));

  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && !pulse_o) |=> !pulse_o);
endmodule

// File: rtl/chg_event_mon.sv
module chg_event_mon
  import cem_pkg::*;
#(
  parameter int unsigned LINES       = 4,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PULSE_CYC   = 1250,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_i,
  input  logic             clr_req_i,
  output logic [CNT_W-1:0] evt_count_o,
  output logic             pulse_o
);
  localparam int unsigned SW = LINES + 1;

  logic [SW-1:0]    sync_q;
  logic [LINES-1:0] req_s;
  logic             clr_s;
  cem_evt_t         evt;

  cem_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({clr_req_i, req_i}),
    .q_o   (sync_q)
  );

  assign req_s = sync_q[LINES-1:0];
  assign clr_s = sync_q[LINES];

  cem_change_det #(.LINES(LINES)) u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_s_i (req_s),
    .clr_s_i (clr_s),
    .evt_o   (evt)
  );

  cem_evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt),
    .count_o (evt_count_o)
  );

  cem_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_i  (evt.chg),
    .pulse_o (pulse_o)
  );

  // R5: counter update and pulse start happen on the same edge
  p_pulse_with_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.chg && !evt.clr_edge) |=> (pulse_o && evt_count_o != $past(evt_count_o)));
endmodule

// File: tb/tb_chg_event_mon.sv
module tb_chg_event_mon;
  localparam int unsigned PULSE = 1250;

  logic        clk;
  logic        rst_n;
  logic [3:0]  req_i;
  logic        clr_req_i;
  logic [15:0] evt_count_o;
  logic        pulse_o;

  int errors = 0;
  int checks = 0;
  logic [15:0] exp_q[$];
  logic [15:0] last_seen;
  logic        mon_en;
  logic        done;

  chg_event_mon dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .clr_req_i   (clr_req_i),
    .evt_count_o (evt_count_o),
    .pulse_o     (pulse_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] v);
    exp_q.push_back(v);
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Returns the number of sampled cycles pulse_o stays high.
  task automatic measure(output int width);
    int guard;
    width = 0;
    guard = 0;
    while (!pulse_o && guard < 20) begin @(negedge clk); guard++; end
    while (pulse_o && width < 5000) begin width++; @(negedge clk); end
  endtask

  // Scoreboard monitor: every count change must match the next expected item.
  always @(negedge clk) begin
    if (rst_n && mon_en && evt_count_o != last_seen) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected count change", int'(evt_count_o), int'(last_seen));
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(evt_count_o == e, "R2 or R4 scoreboard", int'(evt_count_o), int'(e));
      end
      last_seen = evt_count_o;
    end
  end

  // Watchdog
  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int w;
    logic ok_low;
    done = 1'b0;
    mon_en = 1'b0;
    last_seen = 16'd0;
    rst_n = 1'b0;
    req_i = 4'b0000;
    clr_req_i = 1'b0;
    wait_neg(4);
    check(evt_count_o == 16'd0, "R1 count in reset", int'(evt_count_o), 0);
    check(pulse_o == 1'b0, "R1 pulse in reset", int'(pulse_o), 0);
    rst_n = 1'b1;
    mon_en = 1'b1;
    wait_neg(3);

    // R2: idle to line 0, three-edge latency
    req_i = 4'b0001; push(16'd1);
    wait_neg(2);
    check(evt_count_o == 16'd0, "R2 not yet after two edges", int'(evt_count_o), 0);
    wait_neg(1);
    check(evt_count_o == 16'd1, "R2 after third edge", int'(evt_count_o), 1);
    check(pulse_o == 1'b1, "R5 pulse rises with count", int'(pulse_o), 1);
    while (pulse_o) @(negedge clk);
    wait_neg(5);

    // R5: lone event width
    req_i = 4'b0010; push(16'd2);
    measure(w);
    check(w == PULSE, "R5 pulse width", w, PULSE);

    // R7: stays low long after expiry
    ok_low = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (pulse_o) ok_low = 1'b0;
    end
    check(ok_low, "R7 pulse stays low", int'(ok_low), 1);

    // R6: retrigger mid-pulse
    fork
      measure(w);
      begin
        req_i = 4'b0100; push(16'd3);
        wait_neg(600);
        req_i = 4'b1000; push(16'd4);
      end
    join
    check(w == 600 + PULSE, "R6 stretched width", w, 600 + PULSE);

    // R3: drop to idle is not an event
    wait_neg(10);
    req_i = 4'b0000;
    wait_neg(8);
    check(evt_count_o == 16'd4, "R3 count unchanged on idle", int'(evt_count_o), 4);
    check(pulse_o == 1'b0, "R3 no pulse on idle", int'(pulse_o), 0);
    req_i = 4'b1000; push(16'd5);   // return to same line after idle counts
    wait_neg(6);
    check(evt_count_o == 16'd5, "R2 same line after idle", int'(evt_count_o), 5);

    // R8: clear on rising edge only, counting resumes while held high
    clr_req_i = 1'b1; push(16'd0);
    wait_neg(6);
    check(evt_count_o == 16'd0, "R8 cleared", int'(evt_count_o), 0);
    req_i = 4'b0001; push(16'd1);
    wait_neg(6);
    req_i = 4'b0010; push(16'd2);
    wait_neg(6);
    check(evt_count_o == 16'd2, "R8 counting with clear held", int'(evt_count_o), 2);
    clr_req_i = 1'b0;
    wait_neg(6);

    // R9: clear and event in the same cycle
    clr_req_i = 1'b1; req_i = 4'b0100; push(16'd0);
    wait_neg(6);
    check(evt_count_o == 16'd0, "R9 clear wins", int'(evt_count_o), 0);
    req_i = 4'b1000; push(16'd1);
    wait_neg(6);
    check(evt_count_o == 16'd1, "R9 next event after tie", int'(evt_count_o), 1);
    clr_req_i = 1'b0;
    wait_neg(6);

    // R4: 65536 events, crossing the wrap point
    for (int i = 0; i < 65536; i++) begin
      req_i = (i % 2 == 0) ? 4'b0001 : 4'b0010;
      push(16'(1 + i + 1));
      @(negedge clk);
    end
    wait_neg(6);
    check(evt_count_o == 16'd1, "R4 wrapped back", int'(evt_count_o), 1);
    check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule